// File: doc/BRIEF.md
# Write-Through Fully Associative Data Cache

This block is a small data cache for a processor that issues byte loads and byte stores on a narrow byte address. Any line can hold any block. Each line keeps a valid flag, a tag and a block of data words. A request that misses fetches the whole block from memory into the chosen line, one word at a time. This happens for loads and for stores. Every store also sends the single updated byte to memory, so memory always holds the current data. Lines therefore never need a dirty flag, and an eviction never writes anything back.

The processor side is a single request/response handshake. `req_ready` is high only while the cache is idle. A request is accepted on a rising edge with `req_valid` and `req_ready` both high. The result comes back as a one-cycle `resp_valid` pulse, together with a hit flag and, for loads, the byte that was read. The memory side has two ports, each with a request/acknowledge handshake. One is a word read port used for refills. The other is a one-word write port used for stores. Two counters record hits and misses.

Top module: `wt_fa_cache`

## Requirements
- R1: After reset all lines are invalid, `req_ready` is 1, `resp_valid`, `mem_rd_req` and `mem_wr_req` are 0, and both counters are 0.
- R2: A load that hits gives `resp_valid`=1, `resp_hit`=1 and the cached byte in the cycle after acceptance. It causes no memory read and no memory write.
- R3: Any miss reads the whole block. Word 0 is read first, at address {tag,0}, then word 1 at {tag,1}, where the tag is address bits [4:1] and the offset is bit 0. A load miss then returns the addressed byte with `resp_hit`=0.
- R4: Every store, hit or miss, performs exactly one memory write of the store byte to the store address. It also updates the cached copy, so a later load that hits returns the new byte.
- R5: A store miss allocates a line. It completes the block refill before the write-through is issued.
- R6: Evicting a line causes no memory write, so a load, even one that evicts, causes no memory write.
- R7: On a miss, the victim is an invalid line if one exists, lowest index first. Otherwise it is the least recently used line.
- R8: Every accepted access makes the line it touches the most recently used. This covers a hit on that line or a refill into it.
- R9: `req_ready` stays 0 from acceptance until the response. It remains 0 while any memory request is pending. `resp_valid` is a single-cycle pulse. Memory request address and data stay stable until acknowledged.
- R10: `hit_count` and `miss_count` each increase by one for every accepted request that hits or misses, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 5 | Byte address |
| req_wdata | input | 8 | Store byte |
| req_ready | output | 1 | Cache idle and able to accept a request |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Request hit in the cache |
| resp_rdata | output | 8 | Load result (valid with resp_valid on loads) |
| mem_rd_req | output | 1 | Refill word read request |
| mem_rd_addr | output | 5 | Refill word address |
| mem_rd_ack | input | 1 | Read accepted, data present |
| mem_rd_data | input | 8 | Read data |
| mem_wr_req | output | 1 | Write-through request |
| mem_wr_addr | output | 5 | Write-through address |
| mem_wr_data | output | 8 | Write-through byte |
| mem_wr_ack | input | 1 | Write accepted |
| hit_count | output | 16 | Number of hits |
| miss_count | output | 16 | Number of misses |

## Verification
A load hit is due exactly one cycle after the accepting edge. The bench counts falling edges from that edge and requires a latency of one. Misses and stores take a variable number of cycles, because the memory model adds a random wait of zero to two cycles before each acknowledge. For these the bench logs every read and write the memory model acknowledges. When the response pulse arrives, it compares the logged order, the addresses and the byte counts with a reference of tags and recency order. Every output is sampled on the falling edge, half a cycle after the register that drives it changes.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PUT  = 2'd2
  } wtc_state_e;
endpackage

// File: rtl/wtc_tag_match.sv
module wtc_tag_match #(
  parameter int NUM_LINES = 2,
  parameter int TAG_W     = 4,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] line_valid,
  input  logic [TAG_W-1:0]     line_tag [NUM_LINES],
  input  logic [TAG_W-1:0]     look_tag,
  output logic                 hit,
  output logic [IDX_W-1:0]     hit_idx
);
  logic [NUM_LINES-1:0] match;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
    assign match[g] = line_valid[g] && (line_tag[g] == look_tag);
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/wtc_lru.sv
module wtc_lru #(
  parameter int NUM_LINES = 2,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 touch,
  input  logic [IDX_W-1:0]     touch_idx,
  input  logic [NUM_LINES-1:0] line_valid,
  output logic [IDX_W-1:0]     victim_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_LINES - 1);

  logic [IDX_W-1:0] age [NUM_LINES];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age[touch_idx];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst) begin
        age[g] <= IDX_W'(NUM_LINES - 1 - g);
      end else if (touch) begin
        if (touch_idx == IDX_W'(g))
          age[g] <= '0;
        else if (age[g] < touched_age)
          age[g] <= age[g] + IDX_W'(1);
      end
    end
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_idx = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (!found && !line_valid[i]) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
    for (int i = 0; i < NUM_LINES; i++) begin
      if (!found && age[i] == OLDEST) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wtc_data_array.sv
module wtc_data_array #(
  parameter int NUM_LINES = 2,
  parameter int WORDS     = 2,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int OFF_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int DEPTH    = (1 << (IDX_W + OFF_W))
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_line,
  input  logic [OFF_W-1:0]  wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_line,
  input  logic [OFF_W-1:0]  rd_word,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[{wr_line, wr_word}] <= wr_data;
  end

  assign rd_data = store[{rd_line, rd_word}];
endmodule

// File: rtl/wt_fa_cache.sv
module wt_fa_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int WORDS     = 2,
  parameter int NUM_LINES = 2,
  parameter int CNT_W     = 16,
  localparam int OFF_W    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int TAG_W    = ADDR_W - OFF_W,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(WORDS - 1);

  wtc_state_e state;

  logic [NUM_LINES-1:0] line_valid;
  logic [TAG_W-1:0]     line_tag [NUM_LINES];

  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off;
  logic              lookup_hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  victim_idx;
  logic              accept;

  logic              cur_write;
  logic [TAG_W-1:0]  cur_tag;
  logic [OFF_W-1:0]  cur_off;
  logic [DATA_W-1:0] cur_wdata;
  logic [IDX_W-1:0]  cur_line;
  logic [OFF_W-1:0]  fill_word;

  logic              arr_we;
  logic [IDX_W-1:0]  arr_wr_line;
  logic [OFF_W-1:0]  arr_wr_word;
  logic [DATA_W-1:0] arr_wr_data;
  logic [DATA_W-1:0] arr_rd_data;

  assign req_tag   = req_addr[ADDR_W-1:OFF_W];
  assign req_off   = req_addr[OFF_W-1:0];
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  assign mem_rd_req  = (state == ST_FILL);
  assign mem_rd_addr = {cur_tag, fill_word};
  assign mem_wr_req  = (state == ST_PUT);
  assign mem_wr_addr = {cur_tag, cur_off};
  assign mem_wr_data = cur_wdata;

  wtc_tag_match #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_match (
    .line_valid (line_valid),
    .line_tag   (line_tag),
    .look_tag   (req_tag),
    .hit        (lookup_hit),
    .hit_idx    (hit_idx)
  );

  wtc_lru #(.NUM_LINES(NUM_LINES)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .touch      (accept),
    .touch_idx  (lookup_hit ? hit_idx : victim_idx),
    .line_valid (line_valid),
    .victim_idx (victim_idx)
  );

  // One write per cycle: a store hit at acceptance, or one refill word.
  // During a store-miss refill the store byte replaces the fetched word.
  always_comb begin
    arr_we      = 1'b0;
    arr_wr_line = hit_idx;
    arr_wr_word = req_off;
    arr_wr_data = req_wdata;
    if (accept && lookup_hit && req_write) begin
      arr_we = 1'b1;
    end else if (state == ST_FILL && mem_rd_ack) begin
      arr_we      = 1'b1;
      arr_wr_line = cur_line;
      arr_wr_word = fill_word;
      arr_wr_data = (cur_write && fill_word == cur_off) ? cur_wdata : mem_rd_data;
    end
  end

  wtc_data_array #(.NUM_LINES(NUM_LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .we      (arr_we),
    .wr_line (arr_wr_line),
    .wr_word (arr_wr_word),
    .wr_data (arr_wr_data),
    .rd_line (hit_idx),
    .rd_word (req_off),
    .rd_data (arr_rd_data)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        line_valid[g] <= 1'b0;
        line_tag[g]   <= '0;
      end else if (accept && !lookup_hit && victim_idx == IDX_W'(g)) begin
        line_valid[g] <= 1'b0;
        line_tag[g]   <= req_tag;
      end else if (state == ST_FILL && mem_rd_ack && fill_word == LAST_WORD
                   && cur_line == IDX_W'(g)) begin
        line_valid[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      cur_write  <= 1'b0;
      cur_tag    <= '0;
      cur_off    <= '0;
      cur_wdata  <= '0;
      cur_line   <= '0;
      fill_word  <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cur_write <= req_write;
            cur_tag   <= req_tag;
            cur_off   <= req_off;
            cur_wdata <= req_wdata;
            resp_hit  <= lookup_hit;
            if (lookup_hit) begin
              hit_count <= hit_count + CNT_W'(1);
              cur_line  <= hit_idx;
              if (req_write) begin
                state <= ST_PUT;
              end else begin
                resp_valid <= 1'b1;
                resp_rdata <= arr_rd_data;
              end
            end else begin
              miss_count <= miss_count + CNT_W'(1);
              cur_line   <= victim_idx;
              fill_word  <= '0;
              state      <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (mem_rd_ack) begin
            if (!cur_write && fill_word == cur_off) resp_rdata <= mem_rd_data;
            if (fill_word == LAST_WORD) begin
              if (cur_write) begin
                state <= ST_PUT;
              end else begin
                resp_valid <= 1'b1;
                state      <= ST_IDLE;
              end
            end else begin
              fill_word <= fill_word + OFF_W'(1);
            end
          end
        end
        ST_PUT: begin
          if (mem_wr_ack) begin
            resp_valid <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_ack,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              mem_wr_ack,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count,
  input logic              lookup_hit
);
  logic [CNT_W:0] total;
  logic           taken;

  assign total = {1'b0, hit_count} + {1'b0, miss_count};
  assign taken = req_valid && req_ready;

  p_busy_mem_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req || mem_wr_req) |-> !req_ready);

  p_resp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

  p_wr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req && mem_wr_req));

  p_load_hit_r2: assert property (@(posedge clk) disable iff (rst)
    (taken && !req_write && lookup_hit) |=> (resp_valid && resp_hit && !mem_rd_req && !mem_wr_req));

  p_count_step_r10: assert property (@(posedge clk) disable iff (rst)
    taken |=> (total == $past(total) + (CNT_W + 1)'(1)));

  p_count_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !taken |=> $stable(total));
endmodule

bind wt_fa_cache wtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_ready   (req_ready),
  .resp_valid  (resp_valid),
  .resp_hit    (resp_hit),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_ack  (mem_rd_ack),
  .mem_wr_req  (mem_wr_req),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data),
  .mem_wr_ack  (mem_wr_ack),
  .hit_count   (hit_count),
  .miss_count  (miss_count),
  .lookup_hit  (lookup_hit)
);

// File: tb/tb_wt_fa_cache.sv
`timescale 1ns/1ps
module tb_wt_fa_cache;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst;
  logic       req_valid, req_write;
  logic [4:0] req_addr;
  logic [7:0] req_wdata;
  logic       req_ready, resp_valid, resp_hit;
  logic [7:0] resp_rdata;
  logic       mem_rd_req, mem_rd_ack;
  logic [4:0] mem_rd_addr;
  logic [7:0] mem_rd_data;
  logic       mem_wr_req, mem_wr_ack;
  logic [4:0] mem_wr_addr;
  logic [7:0] mem_wr_data;
  logic [15:0] hit_count, miss_count;

  wt_fa_cache dut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] mem_arr [32];
  logic [7:0] gold    [32];
  int         rd_cnt, wr_cnt, rd_wait, wr_wait;
  logic [4:0] rd_log [4];
  logic [4:0] wr_addr_seen;
  logic [7:0] wr_data_seen;

  bit         rv   [2];
  logic [3:0] rtag [2];
  int         rmru;
  int         exp_hits, exp_miss;

  // Memory model: acknowledge after a random 0..2 cycle wait, driven at negedge.
  always @(negedge clk) begin
    mem_rd_ack = 1'b0;
    mem_wr_ack = 1'b0;
    if (!rst && mem_rd_req) begin
      if (rd_wait == 0) begin
        mem_rd_ack  = 1'b1;
        mem_rd_data = mem_arr[mem_rd_addr];
        if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
        rd_cnt++;
        rd_wait = $urandom_range(0, 2);
      end else rd_wait--;
    end
    if (!rst && mem_wr_req) begin
      if (wr_wait == 0) begin
        mem_wr_ack   = 1'b1;
        mem_arr[mem_wr_addr] = mem_wr_data;
        wr_addr_seen = mem_wr_addr;
        wr_data_seen = mem_wr_data;
        wr_cnt++;
        wr_wait = $urandom_range(0, 2);
      end else wr_wait--;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference: invalid-first (lowest index), else the non-MRU line (R7, R8).
  function automatic bit ref_access(input logic [4:0] a);
    logic [3:0] t = a[4:1];
    for (int i = 0; i < 2; i++) begin
      if (rv[i] && rtag[i] == t) begin
        rmru = i;
        exp_hits++;
        return 1'b1;
      end
    end
    begin
      int v;
      if (!rv[0]) v = 0;
      else if (!rv[1]) v = 1;
      else v = 1 - rmru;
      rv[v] = 1'b1;
      rtag[v] = t;
      rmru = v;
      exp_miss++;
    end
    return 1'b0;
  endfunction

  task automatic access(input bit wr, input logic [4:0] a, input logic [7:0] d);
    bit         ph;
    logic [7:0] ev;
    int         lat;
    ph = ref_access(a);
    ev = gold[a];
    if (wr) gold[a] = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_cnt = 0;
    wr_cnt = 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 100) begin
      chk(!req_ready, "R9", "ready while busy", int'(req_ready), 0);
      @(negedge clk);
      lat++;
    end
    chk(resp_valid, "R9", "response arrived", int'(resp_valid), 1);
    chk(resp_hit == ph, "R7", "hit prediction", int'(resp_hit), int'(ph));
    if (!wr) chk(resp_rdata == ev, ph ? "R2" : "R3", "load data", int'(resp_rdata), int'(ev));
    if (ph && !wr) chk(lat == 1, "R2", "hit latency", lat, 1);
    chk(rd_cnt == (ph ? 0 : 2), "R3", "refill reads", rd_cnt, ph ? 0 : 2);
    if (!ph) begin
      chk(rd_log[0] == {a[4:1], 1'b0}, "R3", "first refill addr", int'(rd_log[0]), int'({a[4:1], 1'b0}));
      chk(rd_log[1] == {a[4:1], 1'b1}, "R3", "second refill addr", int'(rd_log[1]), int'({a[4:1], 1'b1}));
    end
    chk(wr_cnt == (wr ? 1 : 0), wr ? "R4" : "R6", "memory writes", wr_cnt, wr ? 1 : 0);
    if (wr) begin
      chk(wr_addr_seen == a, "R4", "write addr", int'(wr_addr_seen), int'(a));
      chk(wr_data_seen == d, "R5", "write data after refill", int'(wr_data_seen), int'(d));
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) begin
      mem_arr[i] = 8'((i * 37 + 11) & 8'hFF);
      gold[i] = mem_arr[i];
    end
    rv[0] = 0; rv[1] = 0; rtag[0] = '0; rtag[1] = '0; rmru = 1;
    exp_hits = 0; exp_miss = 0;
    rd_cnt = 0; wr_cnt = 0; rd_wait = 0; wr_wait = 0;
    mem_rd_ack = 0; mem_wr_ack = 0; mem_rd_data = '0;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "ready", int'(req_ready), 1);
    chk(resp_valid == 1'b0, "R1", "resp_valid", int'(resp_valid), 0);
    chk(!mem_rd_req && !mem_wr_req, "R1", "mem idle", int'({mem_rd_req, mem_wr_req}), 0);
    chk(hit_count == 0 && miss_count == 0, "R1", "counters", int'(hit_count + miss_count), 0);

    // Directed: fills of invalid lines, store hit, store miss, LRU evictions.
    access(0, 5'd3,  8'h00);  // miss, line 0 (R7 invalid first)
    access(0, 5'd12, 8'h00);  // miss, line 1
    access(1, 5'd2,  8'hA5);  // store hit on block of 3 (R4)
    access(0, 5'd2,  8'h00);  // load hit returns stored byte (R4)
    access(1, 5'd9,  8'h3C);  // store miss evicts LRU tag 6 (R5, R7)
    access(0, 5'd20, 8'h00);  // load miss evicts tag 1, no write (R6)
    access(0, 5'd8,  8'h00);  // hit, tag 4 becomes MRU (R8)
    access(0, 5'd27, 8'h00);  // miss evicts tag 10 (R8)
    access(0, 5'd9,  8'h00);  // hit survives (R8)
    access(1, 5'd27, 8'h77);  // store hit
    access(0, 5'd26, 8'h00);  // hit other word of block

    // Random mix on a narrow address range to provoke hits.
    for (int n = 0; n < 400; n++) begin
      logic [4:0] a;
      a = 5'($urandom_range(0, 11));
      if ($urandom_range(0, 3) == 0) a = 5'($urandom_range(0, 31));
      access($urandom_range(0, 2) == 0, a, 8'($urandom));
    end

    @(negedge clk);
    chk(hit_count == 16'(exp_hits), "R10", "hit counter", int'(hit_count), exp_hits);
    chk(miss_count == 16'(exp_miss), "R10", "miss counter", int'(miss_count), exp_miss);
    begin
      int bad = 0;
      for (int i = 0; i < 32; i++) if (mem_arr[i] != gold[i]) bad++;
      chk(bad == 0, "R4", "memory image mismatches", bad, 0);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule